// File: doc/BRIEF.md
# Unlock Command Sequence Detector

This block sits beside the write path of a byte-wide nonvolatile memory. It watches each bus write (a strobe with a 17-bit address and an 8-bit data byte) and keeps a software write-protection flag. A short arming sequence of three magic writes turns protection on. A longer six-write release sequence turns it off. For every write it also decides, in the same cycle, whether that write may go on to the memory array.

Protection is off after reset, so every write reaches the array. Once protection is on, the array accepts only payload writes. These are writes that arrive inside a timed window, which opens when an arming sequence completes and restarts with each payload write. All other writes are held back, and that includes the magic writes themselves. Only the low 15 address bits take part in recognising the magic writes. The sequencing of the array's own programming is handled elsewhere.

Top module: `wr_seq_guard`

## Requirements
- R1: After reset `prot_on` is 0, and `commit_ok` is 0 whenever `wr_valid` is 0.
- R2: While `prot_on` is 0, every write, magic or not, gives `commit_ok` = 1 in its own cycle.
- R3: The writes data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555 (no other writes between them) set `prot_on` to 1 from the cycle after the third write. No further write is needed for this.
- R4: While `prot_on` is 1 and the payload window is closed, every write gives `commit_ok` = 0. This includes all writes that form an arming or release sequence.
- R5: Completing an arming sequence opens a payload window of WIN_CYC cycles. If the third arming write is in cycle c, then a write to any address in cycles c+1 to c+WIN_CYC gives `commit_ok` = 1.
- R6: Each payload write reloads the window to WIN_CYC cycles, counted from the following cycle. A write that comes WIN_CYC+1 or more cycles after the last reload is blocked.
- R7: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clear `prot_on` and close the window from the next cycle. Writes after that commit again.
- R8: A write that does not match the next expected step sends the matcher back to idle. If that write is itself 0xAA@0x5555, it is counted as the first step of a new sequence.
- R9: Address bits 16 and 15 are ignored when magic writes are recognised.
- R10: While the window is open, every write is treated as payload and does not advance the sequence matcher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A bus write is present this cycle |
| wr_addr | input | 17 | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| prot_on | output | 1 | Software write protection is active |
| commit_ok | output | 1 | The write in this cycle may be passed to the array |

## Verification
The bench probes the window edges exactly. It writes after WIN_CYC-1 idle cycles and after WIN_CYC idle cycles, so an off-by-one counter either drops a legal payload or lets a late write through. It breaks a half-finished sequence with a stray 0xAA@0x5555 and shows that the sequence still completes from there; a matcher that always returns to idle would leave protection off. It also checks that magic writes stay blocked while protection holds, and that enabling works with the upper address bits set. A design that compares all 17 address bits would miss that arming.

// File: rtl/wsg_pkg.sv
// Shared definitions for the write-sequence guard.
// Holds the matcher state type and the table of magic (address, data) keys.
// Assumes the compared address slice is 15 bits and magic data is one byte.
package wsg_pkg;

    localparam int CMP_W = 15;
    localparam int NKEY  = 5;

    // Key indices into the magic table
    localparam int K_LEAD  = 0;   // 0xAA @ 0x5555
    localparam int K_SWAP  = 1;   // 0x55 @ 0x2AAA
    localparam int K_ARM   = 2;   // 0xA0 @ 0x5555
    localparam int K_ESC   = 3;   // 0x80 @ 0x5555
    localparam int K_DROP  = 4;   // 0x20 @ 0x5555

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_SWAP,
        SQ_ESC,
        SQ_LEAD2,
        SQ_SWAP2
    } seq_st_t;

    function automatic logic [CMP_W-1:0] key_addr(input int k);
        return (k == K_SWAP) ? 15'h2AAA : 15'h5555;
    endfunction

    function automatic logic [7:0] key_data(input int k);
        case (k)
            K_LEAD:  return 8'hAA;
            K_SWAP:  return 8'h55;
            K_ARM:   return 8'hA0;
            K_ESC:   return 8'h80;
            default: return 8'h20;
        endcase
    endfunction

endpackage

// File: rtl/wsg_seq_match.sv
// Magic write sequence matcher.
// Tracks progress through the arming (3 writes) and release (6 writes)
// sequences. It raises arm_hit or rel_hit in the cycle of the final write.
// Assumes step_vld is already gated off for payload writes.
module wsg_seq_match
    import wsg_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              arm_hit,
    output logic              rel_hit
);

    seq_st_t        st_q, st_d;
    logic [NKEY-1:0] key_hit;
    seq_st_t        restart;

    // One comparator per magic key, low address slice only
    for (genvar k = 0; k < NKEY; k++) begin : g_key
        assign key_hit[k] = step_vld
                          && (addr[CMP_W-1:0] == key_addr(k))
                          && (data == DATA_W'(key_data(k)));
    end

    // Where a broken sequence resumes: a lead write starts over at step one
    assign restart = key_hit[K_LEAD] ? SQ_LEAD : SQ_IDLE;

    // Next-state and completion decode for the current write
    always_comb begin
        st_d    = st_q;
        arm_hit = 1'b0;
        rel_hit = 1'b0;
        if (step_vld) begin
            case (st_q)
                SQ_IDLE:  st_d = restart;
                SQ_LEAD:  st_d = key_hit[K_SWAP] ? SQ_SWAP : restart;
                SQ_SWAP: begin
                    if (key_hit[K_ARM]) begin
                        arm_hit = 1'b1;
                        st_d    = SQ_IDLE;
                    end else if (key_hit[K_ESC]) begin
                        st_d = SQ_ESC;
                    end else begin
                        st_d = restart;
                    end
                end
                SQ_ESC:   st_d = key_hit[K_LEAD] ? SQ_LEAD2 : SQ_IDLE;
                SQ_LEAD2: st_d = key_hit[K_SWAP] ? SQ_SWAP2 : restart;
                SQ_SWAP2: begin
                    if (key_hit[K_DROP]) begin
                        rel_hit = 1'b1;
                        st_d    = SQ_IDLE;
                    end else begin
                        st_d = restart;
                    end
                end
                default:  st_d = SQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    // R3
    arm_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_hit |=> (st_q == SQ_IDLE));

    // R8
    lead_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && key_hit[K_LEAD] && st_q != SQ_ESC) |=> (st_q == SQ_LEAD));

    // R10
    hold_when_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_vld |=> $stable(st_q));

endmodule

// File: rtl/wsg_pay_window.sv
// Payload window timer.
// Loads WIN_CYC when armed or on a payload write, then counts down once a
// cycle. The window is open while the count is nonzero. Clear wins over all.
// Assumes arm and hit never coincide (hit needs an open window; arm needs a
// closed one).
module wsg_pay_window #(
    parameter int WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hit,
    input  logic clear,
    output logic open
);

    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Reload on arm or payload, otherwise run down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clear)       cnt_q <= '0;
        else if (arm || hit)  cnt_q <= CNT_MAX;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign open = (cnt_q != '0);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R5
    arm_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clear) |=> open);

    // R6
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 1 && !arm && !hit) |=> !open);

endmodule

// File: rtl/wr_seq_guard.sv
// Write-sequence guard, top level.
// Holds the protection flag and gates each bus write toward the array.
// Writes inside an open payload window are payload. All others feed the
// sequence matcher. The commit decision is combinational in the write cycle.
// Assumes at most one write per cycle and ADDR_W >= 15.
module wr_seq_guard
    import wsg_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int WIN_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot_on,
    output logic              commit_ok
);

    logic win_open;
    logic step_vld;
    logic pay_wr;
    logic arm_hit;
    logic rel_hit;
    logic prot_q;

    // Split writes into payload and sequence candidates
    assign pay_wr   = wr_valid && win_open;
    assign step_vld = wr_valid && !win_open;

    wsg_seq_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_vld (step_vld),
        .addr     (wr_addr),
        .data     (wr_data),
        .arm_hit  (arm_hit),
        .rel_hit  (rel_hit)
    );

    wsg_pay_window #(
        .WIN_CYC (WIN_CYC)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm_hit),
        .hit   (pay_wr),
        .clear (rel_hit),
        .open  (win_open)
    );

    // Protection flag: set by arming, cleared by release
    always_ff @(posedge clk) begin
        if (!rst_n)       prot_q <= 1'b0;
        else if (rel_hit) prot_q <= 1'b0;
        else if (arm_hit) prot_q <= 1'b1;
    end

    assign prot_on   = prot_q;
    assign commit_ok = wr_valid && (!prot_q || win_open);

    // R1
    commit_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok |-> wr_valid);

    // R3
    prot_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(arm_hit));

    // R4
    locked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && !win_open) |-> !commit_ok);

    // R5
    window_implies_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> prot_on);

    // R7
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_hit |=> (!prot_on && !win_open));

endmodule

// File: tb/wr_seq_guard_bench.sv
module wr_seq_guard_bench;

    localparam int WIN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prot_on;
    logic        commit_ok;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wr_seq_guard #(
        .ADDR_W  (17),
        .DATA_W  (8),
        .WIN_CYC (WIN)
    ) u_wr_seq_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prot_on   (prot_on),
        .commit_ok (commit_ok)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // One write cycle, started just after a falling edge; returns after the next one
    task automatic do_wr(input logic [16:0] a, input logic [7:0] d,
                         input logic exp_commit, input string tag);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        #1;
        chk(commit_ok, exp_commit, tag);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_seq(input logic exp_commit, input string tag);
        do_wr(17'h05555, 8'hAA, exp_commit, tag);
        do_wr(17'h02AAA, 8'h55, exp_commit, tag);
        do_wr(17'h05555, 8'hA0, exp_commit, tag);
    endtask

    task automatic rel_seq(input logic exp_commit, input string tag);
        do_wr(17'h05555, 8'hAA, exp_commit, tag);
        do_wr(17'h02AAA, 8'h55, exp_commit, tag);
        do_wr(17'h05555, 8'h80, exp_commit, tag);
        do_wr(17'h05555, 8'hAA, exp_commit, tag);
        do_wr(17'h02AAA, 8'h55, exp_commit, tag);
        do_wr(17'h05555, 8'h20, exp_commit, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk(prot_on, 1'b0, "R1 prot after reset");
        chk(commit_ok, 1'b0, "R1 commit idle");
        rst_n = 1'b1;
        idle(1);
        chk(prot_on, 1'b0, "R1 prot after release of reset");
    endtask

    task automatic t_unprot();
        do_wr(17'h00123, 8'h5A, 1'b1, "R2 plain write");
        do_wr(17'h05555, 8'hAA, 1'b1, "R2 magic write unprotected");
        do_wr(17'h02AAA, 8'h55, 1'b1, "R2 magic write unprotected");
        chk(prot_on, 1'b0, "R3 partial sequence leaves prot off");
        do_wr(17'h00000, 8'h00, 1'b1, "R2 breaking write");
        do_wr(17'h05555, 8'hA0, 1'b1, "R8 stale third step");
        chk(prot_on, 1'b0, "R8 broken sequence does not arm");
    endtask

    task automatic t_window();
        arm_seq(1'b1, "R2 arming writes commit");
        chk(prot_on, 1'b1, "R3 prot on after arming");
        idle(WIN - 1);
        do_wr(17'h1F00F, 8'h11, 1'b1, "R5 payload at last window cycle");
        idle(WIN - 1);
        do_wr(17'h00400, 8'h22, 1'b1, "R6 reloaded window");
        idle(WIN);
        do_wr(17'h00400, 8'h33, 1'b0, "R6 write after expiry");
        chk(prot_on, 1'b1, "R4 prot holds");
    endtask

    task automatic t_locked();
        do_wr(17'h00777, 8'h01, 1'b0, "R4 plain write blocked");
        arm_seq(1'b0, "R4 arming writes blocked while protected");
        chk(prot_on, 1'b1, "R3 prot stays on");
        do_wr(17'h05555, 8'hAA, 1'b1, "R10 magic-looking write is payload");
        do_wr(17'h02AAA, 8'h55, 1'b1, "R10 payload continues");
        idle(WIN + 2);
    endtask

    task automatic t_release();
        rel_seq(1'b0, "R4 release writes blocked");
        chk(prot_on, 1'b0, "R7 prot off after release");
        do_wr(17'h00010, 8'h44, 1'b1, "R7 write commits after release");
    endtask

    task automatic t_mismatch();
        do_wr(17'h05555, 8'hAA, 1'b1, "R8 step one");
        do_wr(17'h02AAA, 8'h55, 1'b1, "R8 step two");
        do_wr(17'h05555, 8'hAA, 1'b1, "R8 lead write restarts");
        do_wr(17'h02AAA, 8'h55, 1'b1, "R8 step two again");
        do_wr(17'h05555, 8'hA0, 1'b1, "R8 step three");
        chk(prot_on, 1'b1, "R8 restarted sequence arms");
        idle(WIN + 2);
        rel_seq(1'b0, "R4 release writes blocked");
        chk(prot_on, 1'b0, "R7 released");
        do_wr(17'h05555, 8'hAA, 1'b1, "R8 step one");
        do_wr(17'h02AAA, 8'h55, 1'b1, "R8 step two");
        do_wr(17'h05555, 8'h12, 1'b1, "R8 wrong data");
        do_wr(17'h02AAA, 8'h55, 1'b1, "R8 out of order");
        do_wr(17'h05555, 8'hA0, 1'b1, "R8 out of order");
        chk(prot_on, 1'b0, "R8 mismatch returned to idle");
    endtask

    task automatic t_upper();
        do_wr(17'h1D555, 8'hAA, 1'b1, "R9 high bits step one");
        do_wr(17'h12AAA, 8'h55, 1'b1, "R9 high bits step two");
        do_wr(17'h0D555, 8'hA0, 1'b1, "R9 high bits step three");
        chk(prot_on, 1'b1, "R9 arming ignores upper address bits");
        idle(WIN + 2);
        rel_seq(1'b0, "R4 release writes blocked");
        chk(prot_on, 1'b0, "R7 released again");
    endtask

    initial begin
        idle(1);
        t_reset();
        t_unprot();
        t_window();
        t_locked();
        t_release();
        t_mismatch();
        t_upper();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule